// File: doc/BRIEF.md
# Unaligned Read Combiner

This block sits between a processor's load path and a memory that only returns whole, naturally aligned 32-bit words. The processor asks for a 32-bit or a 16-bit value starting at any byte address. If every requested byte lies inside one memory word, the block performs one word read and moves the wanted bytes into place. If the bytes run past the end of a word, it performs two word reads on back-to-back cycles: first the word that holds the start address, then the next word up. It keeps the first word in a holding register and then merges the two words byte by byte into one result.

Memory bytes are big-endian: the byte at the lowest address of a word sits in bits 31:24. The processor side uses a request/ready handshake and gets the answer as a one-cycle valid pulse. The memory side is a read strobe plus a word-aligned byte address. Its data appears in the cycle after the strobe and holds until the next strobe. Word addresses wrap modulo 2^32.

Top module: `unaligned_read_combiner`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `req_ready` is 1, and `rsp_valid` and `mem_rd` are 0.
- R2: A 32-bit read (`req_half`=0) at address A returns the byte at A in bits 31:24, A+1 in 23:16, A+2 in 15:8 and A+3 in 7:0. With bytes 0x01..0x08 at addresses 0..7, a read at address 1 returns 0x02030405.
- R3: A 16-bit read (`req_half`=1) at address A returns the byte at A in bits 15:8 and the byte at A+1 in bits 7:0. Bits 31:16 are zero.
- R4: When the requested bytes lie in one word, the block issues exactly one memory read. That is the case for a 32-bit read with A[1:0]=0, and for a 16-bit read with A[1:0] equal to 0, 1 or 2. The read address is A with bits 1:0 cleared. `rsp_valid` rises 3 clock edges after the edge on which the block drove the request.
- R5: When the bytes cross a word boundary, the block issues exactly two memory reads, on consecutive cycles. That is the case for a 32-bit read with A[1:0]≠0, and for a 16-bit read with A[1:0]=3. The first read is at A with bits 1:0 cleared, the second is 4 bytes higher, and the response comes one cycle later than in R4.
- R6: The second word address wraps modulo 2^32, so a crossing read near 0xFFFFFFFF takes its upper bytes from address 0 onward.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the cycle in which its `rsp_valid` is high. A `req_valid` seen while `req_ready` is 0 starts no read and produces no response.
- R8: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long.
- R9: Whenever `mem_rd` is 1, `mem_addr[1:0]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Byte address of the first requested byte |
| req_half | input | 1 | 1 = 16-bit read, 0 = 32-bit read |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the result |
| rsp_data | output | 32 | Assembled read value |
| mem_rd | output | 1 | Word read strobe to memory |
| mem_addr | output | 32 | Word-aligned byte address of the read |
| mem_rdata | input | 32 | Memory word, valid the cycle after `mem_rd` |

## Verification
Suppose the bench drives a request just before edge C+1. Then the first memory strobe is seen after edge C+1 and any second strobe after edge C+2. The response is due after edge C+3 when one read is enough and after edge C+4 when the bytes cross a word. The driver pushes the expected word addresses, the data and that exact due cycle into scoreboard queues. The monitor samples on the falling edge, pops an entry for every strobe and every response, and compares both the value and the cycle. An extra strobe or response pops an empty queue and counts as a failure, and anything left in the queues at the end is reported as missing.

// File: rtl/ura_pkg.sv
// Shared types for the unaligned read combiner.
package ura_pkg;
    // Controller phases: idle, first strobe, first word back, second word back.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } ura_state_e;
endpackage

// File: rtl/ura_ctrl.sv
// Sequencer for the combiner. It accepts one request at a time and decides
// whether the bytes cross a word. It drives one or two aligned word reads.
// Assumes the memory returns data in the cycle after each strobe.
module ura_ctrl
    import ura_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES = 4,
    parameter int NARROW_LANES = 2,
    parameter int OFF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_half,
    output logic              req_ready,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [OFF_W-1:0]  off,
    output logic              half,
    output logic              split,
    output ura_state_e        state
);
    localparam int SPAN_W = OFF_W + 2;

    ura_state_e        state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic              half_q;
    logic [SPAN_W-1:0] span;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] upper;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            half_q <= 1'b0;
        end else if (req_valid && state == ST_IDLE) begin
            addr_q <= req_addr;
            half_q <= req_half;
        end
    end

    // Byte span, crossing test, and the two aligned addresses.
    always_comb begin
        off   = addr_q[OFF_W-1:0];
        half  = half_q;
        span  = SPAN_W'(off) + (half_q ? SPAN_W'(NARROW_LANES) : SPAN_W'(LANES));
        split = span > SPAN_W'(LANES);
        base  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        upper = base + ADDR_W'(LANES);
    end

    // Next phase and the memory strobe.
    always_comb begin
        state_nx  = state;
        req_ready = (state == ST_IDLE);
        mem_rd    = 1'b0;
        mem_addr  = base;
        case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ISSUE;
            ST_ISSUE: begin
                mem_rd   = 1'b1;
                state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (split) begin
                    mem_rd   = 1'b1;
                    mem_addr = upper;
                    state_nx = ST_HIGH;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ura_merge.sv
// Byte-lane merger. It treats {first, second} as a run of big-endian bytes and
// takes LANES bytes starting at byte 'off'. Narrow results sit at the low end,
// with zeros above them.
module ura_merge #(
    parameter int DATA_W = 32,
    parameter int NARROW_W = 16,
    parameter int OFF_W = 2
) (
    input  logic [DATA_W-1:0] first,
    input  logic [DATA_W-1:0] second,
    input  logic [OFF_W-1:0]  off,
    input  logic              half,
    output logic [DATA_W-1:0] result
);
    localparam int LANES = DATA_W / 8;

    logic [2*DATA_W-1:0] cat;
    logic [DATA_W-1:0]   wide;

    assign cat = {first, second};

    // One selector per output byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wide[DATA_W-1-8*g -: 8] = cat[2*DATA_W-1-8*(g+int'(off)) -: 8];
    end

    // Pick the full-width or the narrow form.
    always_comb begin
        if (half) result = {{(DATA_W-NARROW_W){1'b0}}, wide[DATA_W-1 -: NARROW_W]};
        else      result = wide;
    end
endmodule

// File: rtl/unaligned_read_combiner.sv
// Top of the combiner. Serves 16-bit and full-width reads at any byte address
// from a memory that only delivers aligned words. Results are registered and
// flagged by a one-cycle valid pulse.
module unaligned_read_combiner
    import ura_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_half,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int NARROW_LANES = NARROW_W / 8;
    localparam int OFF_W = $clog2(LANES);

    ura_state_e        state;
    logic [OFF_W-1:0]  off;
    logic              half;
    logic              split;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] first_w;
    logic [DATA_W-1:0] merged;
    logic              load;

    ura_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .NARROW_LANES(NARROW_LANES), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_half(req_half), .req_ready(req_ready), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .off(off), .half(half), .split(split), .state(state)
    );

    // The first word comes from the holding register once the second word arrives.
    assign first_w = (state == ST_HIGH) ? hold_q : mem_rdata;
    assign load    = (state == ST_LOW && !split) || state == ST_HIGH;

    ura_merge #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .OFF_W(OFF_W)
    ) u_merge (
        .first(first_w), .second(mem_rdata), .off(off), .half(half), .result(merged)
    );

    // Keep the lower word while the upper one is being fetched.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hold_q <= '0;
        else if (state == ST_LOW && split) hold_q <= mem_rdata;
    end

    // Register the result and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= load;
            if (load) rsp_data <= merged;
        end
    end
endmodule

// File: rtl/ura_chk.sv
// Protocol checker for the combiner. It is bound to the top and watches only
// its ports.
module ura_chk #(
    parameter int ADDR_W = 32,
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr
);
    // R9
    aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr[OFF_W-1:0] == '0);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    idle_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R5
    second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> mem_addr == $past(mem_addr) + ADDR_W'(LANES));

    // R5
    two_reads_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |=> !mem_rd);
endmodule

bind unaligned_read_combiner ura_chk #(
    .ADDR_W(ADDR_W), .LANES(LANES), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/unaligned_read_combiner_test.sv
// Scoreboard bench: the driver queues expected reads and responses, and the
// monitor pops and compares them on the falling edge.
module unaligned_read_combiner_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_half = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [31:0] q_data[$];
    int          q_due[$];
    string       q_req[$];
    logic [31:0] q_maddr[$];
    string       q_mreq[$];

    unaligned_read_combiner uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_half(req_half), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Memory contents as a function of the byte address; bytes 0..7 hold 1..8.
    function automatic logic [7:0] bval(logic [31:0] a);
        return (a[7:0] + 8'd1) ^ a[31:24];
    endfunction

    // Word memory with one cycle of read latency, big-endian byte order.
    always @(posedge clk)
        if (mem_rd)
            mem_rdata <= {bval(mem_addr), bval(mem_addr + 32'd1),
                          bval(mem_addr + 32'd2), bval(mem_addr + 32'd3)};

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Queue the expectations for one request, then drive it.
    task automatic send(logic [31:0] a, bit half, string req, bit poke);
        bit          crosses;
        logic [31:0] exp;
        logic [31:0] base;
        while (1) begin
            @(negedge clk);
            if (req_ready) break;
        end
        crosses = half ? (a[1:0] == 2'd3) : (a[1:0] != 2'd0);
        exp = half ? {16'h0, bval(a), bval(a + 32'd1)}
                   : {bval(a), bval(a + 32'd1), bval(a + 32'd2), bval(a + 32'd3)};
        base = {a[31:2], 2'b00};
        q_maddr.push_back(base);
        q_mreq.push_back(crosses ? "R5" : "R4");
        if (crosses) begin
            q_maddr.push_back(base + 32'd4);
            q_mreq.push_back("R5/R6");
        end
        q_data.push_back(exp);
        q_due.push_back(cyc + (crosses ? 4 : 3));
        q_req.push_back(req);
        req_valid = 1'b1;
        req_addr  = a;
        req_half  = half;
        @(negedge clk);
        chk(req_ready == 1'b0, "R7 ready low while busy", {31'b0, req_ready}, 32'h0);
        if (poke) begin
            req_addr = a + 32'h40;
            req_half = ~half;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Monitor: compare strobes and responses against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                if (q_maddr.size() == 0)
                    chk(1'b0, "R4/R5 unexpected read", mem_addr, 32'hx);
                else
                    chk(mem_addr == q_maddr[0], q_mreq[0], mem_addr, q_maddr[0]);
                if (q_maddr.size() != 0) begin
                    void'(q_maddr.pop_front());
                    void'(q_mreq.pop_front());
                end
            end
            if (rsp_valid) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R7/R8 unexpected response", rsp_data, 32'hx);
                end else begin
                    chk(rsp_data == q_data[0], q_req[0], rsp_data, q_data[0]);
                    chk(cyc == q_due[0], "R4/R5 response cycle", cyc, q_due[0]);
                    void'(q_data.pop_front());
                    void'(q_due.pop_front());
                    void'(q_req.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        wait (cyc == 20000);
        chk(1'b0, "watchdog", cyc, 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd, "R1 reset state",
            {29'b0, req_ready, rsp_valid, mem_rd}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd, "R1 after release",
            {29'b0, req_ready, rsp_valid, mem_rd}, 32'h4);

        send(32'h0000_0000, 1'b0, "R2 aligned word", 1'b0);
        send(32'h0000_0001, 1'b0, "R2 offset 1 (0x02030405)", 1'b0);
        send(32'h0000_0002, 1'b0, "R2 offset 2", 1'b0);
        send(32'h0000_0003, 1'b0, "R2 offset 3", 1'b0);
        send(32'h0000_0004, 1'b0, "R2 aligned word 2", 1'b0);
        send(32'h0000_0005, 1'b1, "R3 half in word", 1'b0);
        send(32'h0000_0008, 1'b1, "R3 half offset 0", 1'b0);
        send(32'h0000_0016, 1'b1, "R3 half offset 2", 1'b0);
        send(32'h0000_0017, 1'b1, "R3 half offset 3 crossing", 1'b0);
        send(32'h1234_567D, 1'b0, "R2 high address", 1'b1);
        send(32'h0000_0031, 1'b1, "R7 busy request ignored", 1'b1);
        send(32'hFFFF_FFFE, 1'b0, "R6 wrap word", 1'b0);
        send(32'hFFFF_FFFF, 1'b1, "R6 wrap half", 1'b0);
        send(32'hFFFF_FFFC, 1'b0, "R6 last aligned", 1'b0);

        repeat (6) @(negedge clk);
        chk(q_data.size() == 0, "R8 missing response", q_data.size(), 32'h0);
        chk(q_maddr.size() == 0, "R4/R5 missing read", q_maddr.size(), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule